// File: doc/BRIEF.md
# Single-Bit Alias Bridge for Word SRAM

This bridge sits between one memory-mapped master and a word-wide synchronous SRAM. Two address windows are decoded. The backing window is 1 MB wide at 0x2000_0000, and accesses there reach the SRAM as plain 32-bit reads and writes. The alias window is 32 MB wide at 0x2200_0000. Each 32-bit word in the alias window stands for a single bit of the backing window.

A read of an alias word returns that one bit, zero-extended. A write to an alias word updates that one bit through an internal read-modify-write. The master is held off until the write-back completes, so no other access can reach the backing word in between.

Firmware uses the alias window as a set of atomic event flags. A flag can be set or cleared with one store, without a software read-modify-write. An address-hit output lets an outer decoder send addresses that fall outside both windows to another target.

Top module: `bitband_bridge`

## Requirements
- R1: After a synchronous active-high reset, `m_ready` is low and the sequencer is idle.
- R2: `m_hit` is high exactly when `m_valid` is high and the address lies in [0x2000_0000, 0x2010_0000) or [0x2200_0000, 0x2400_0000). An address outside both windows is never acknowledged.
- R3: A backing-window write stores the full 32-bit word, and a backing-window read returns it unchanged. Both raise `m_ready` in the second cycle of the request, after one memory cycle.
- R4: Alias address A selects byte offset B = (A − 0x2200_0000) / 32 and bit n = ((A − 0x2200_0000) / 4) mod 8. That bit is bit (B mod 4)·8 + n of backing word B / 4, with little-endian byte lanes.
- R5: An alias write takes the new bit value from write-data bit 0 alone. Write-data bits 31:1 have no effect, so 0xFF acts like 0x01 and 0x0E acts like 0x00.
- R6: An alias write leaves the other 31 bits of the backing word unchanged.
- R7: An alias read returns 0x0000_0001 when the target bit is set and 0x0000_0000 when it is clear.
- R8: An alias write holds `m_ready` low for two memory cycles, a read and then a write-back, and raises it in the third cycle. An alias read completes like a backing read. `m_ready` is high for one cycle per access.
- R9: The write-back of an alias write goes to the same word that its read fetched, in the cycle right after it. No other memory access comes between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_valid | input | 1 | Master request valid, held until `m_ready` |
| m_write | input | 1 | 1 = write, 0 = read |
| m_addr | input | 32 | Byte address |
| m_wdata | input | 32 | Write data |
| m_ready | output | 1 | Access complete, one-cycle pulse |
| m_rdata | output | 32 | Read data, valid with `m_ready` on reads |
| m_hit | output | 1 | Request address falls in one of the two windows |

## Verification
The assertions assume a well-behaved master. It keeps `m_valid`, `m_write`, `m_addr` and `m_wdata` steady from the cycle it raises `m_valid` until the cycle after it sees `m_ready`, and it never withdraws a request that hits a window. The bench driver meets this by setting all request fields together on a falling edge and holding them there. It drops `m_valid` only just after the rising edge that completes the handshake. Requests that miss both windows are withdrawn after a few cycles without an acknowledge, which the block permits for misses. The SRAM has no reset, so every word the bench later reads through the alias window is first written in full through the backing window.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned POS_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MODIFY = 2'd1,
    ST_ACK    = 2'd2
  } seq_state_e;

  function automatic logic [DATA_W-1:0] put_bit(input logic [DATA_W-1:0] word,
                                                input logic [POS_W-1:0]  pos,
                                                input logic              val);
    logic [DATA_W-1:0] res;
    res      = word;
    res[pos] = val;
    return res;
  endfunction
endpackage

// File: rtl/bb_decode.sv
module bb_decode
  import bb_pkg::*;
#(
  parameter logic [ADDR_W-1:0] BACK_BASE  = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000,
  parameter int unsigned       BACK_LOG2  = 20,
  parameter int unsigned       IDX_W      = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              back_hit,
  output logic              alias_hit,
  output logic [IDX_W-1:0]  word_idx,
  output logic [POS_W-1:0]  bit_pos
);
  localparam int unsigned ALIAS_LOG2 = BACK_LOG2 + 5;

  // Window bases are aligned to their size, so a window hit is an upper-bit compare.
  always_comb begin
    back_hit  = (addr[ADDR_W-1:BACK_LOG2]  == BACK_BASE[ADDR_W-1:BACK_LOG2]);
    alias_hit = (addr[ADDR_W-1:ALIAS_LOG2] == ALIAS_BASE[ADDR_W-1:ALIAS_LOG2]);
    // Each alias word stands for one bit, so one backing word spans 32 alias words (128 bytes).
    bit_pos   = addr[POS_W+1:2];
    if (alias_hit) word_idx = addr[IDX_W+6:7];
    else           word_idx = addr[IDX_W+1:2];
  end
endmodule

// File: rtl/bb_sram.sv
module bb_sram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Read-first single port, one-cycle read latency.
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
  import bb_pkg::*;
#(
  parameter logic [31:0] BACK_BASE  = 32'h2000_0000,
  parameter logic [31:0] ALIAS_BASE = 32'h2200_0000,
  parameter int unsigned BACK_LOG2  = 20,
  parameter int unsigned RAM_AW     = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        m_valid,
  input  logic        m_write,
  input  logic [31:0] m_addr,
  input  logic [31:0] m_wdata,
  output logic        m_ready,
  output logic [31:0] m_rdata,
  output logic        m_hit
);
  seq_state_e        state;
  logic              back_hit, alias_hit;
  logic [RAM_AW-1:0] dec_idx, idx_q;
  logic [POS_W-1:0]  dec_pos, pos_q;
  logic              alias_q, write_q, wbit_q;
  logic              accept;
  logic              ram_en, ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_q;

  bb_decode #(
    .BACK_BASE (BACK_BASE),
    .ALIAS_BASE(ALIAS_BASE),
    .BACK_LOG2 (BACK_LOG2),
    .IDX_W     (RAM_AW)
  ) u_dec (
    .addr     (m_addr),
    .back_hit (back_hit),
    .alias_hit(alias_hit),
    .word_idx (dec_idx),
    .bit_pos  (dec_pos)
  );

  bb_sram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk  (clk),
    .en   (ram_en),
    .we   (ram_we),
    .addr (ram_addr),
    .wdata(ram_wdata),
    .q    (ram_q)
  );

  assign m_hit  = m_valid && (back_hit || alias_hit);
  assign accept = (state == ST_IDLE) && m_hit;

  always_comb begin
    ram_en    = accept || (state == ST_MODIFY);
    ram_we    = (accept && m_write && !alias_hit) || (state == ST_MODIFY);
    ram_addr  = (state == ST_MODIFY) ? idx_q : dec_idx;
    ram_wdata = (state == ST_MODIFY) ? put_bit(ram_q, pos_q, wbit_q) : m_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx_q   <= '0;
      pos_q   <= '0;
      alias_q <= 1'b0;
      write_q <= 1'b0;
      wbit_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          idx_q   <= dec_idx;
          pos_q   <= dec_pos;
          alias_q <= alias_hit;
          write_q <= m_write;
          wbit_q  <= m_wdata[0];
          state   <= (alias_hit && m_write) ? ST_MODIFY : ST_ACK;
        end
        ST_MODIFY: state <= ST_ACK;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    m_ready = (state == ST_ACK);
    m_rdata = '0;
    if (m_ready && !write_q) m_rdata = alias_q ? {{(DATA_W-1){1'b0}}, ram_q[pos_q]} : ram_q;
  end

  assert_miss_not_acked_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && m_valid && !m_hit) |=> !m_ready);

  assert_rmw_same_word_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MODIFY) |-> (ram_we && ram_addr == $past(ram_addr) && $past(ram_en) && !$past(ram_we)));

  assert_one_bit_changes_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MODIFY) |-> ($countones(ram_wdata ^ ram_q) <= 1));

  assert_alias_write_two_cycles_R8: assert property (@(posedge clk) disable iff (rst)
    (accept && alias_hit && m_write) |=> (!m_ready ##1 m_ready));

  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    m_ready |=> !m_ready);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> !m_ready);
endmodule

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;
  localparam logic [31:0] BACK  = 32'h2000_0000;
  localparam logic [31:0] ALIAS = 32'h2200_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        m_valid = 1'b0, m_write = 1'b0;
  logic [31:0] m_addr = '0, m_wdata = '0;
  logic        m_ready, m_hit;
  logic [31:0] m_rdata;

  always #4 clk = ~clk;

  bitband_bridge dut (
    .clk(clk), .rst(rst), .m_valid(m_valid), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_ready(m_ready),
    .m_rdata(m_rdata), .m_hit(m_hit)
  );

  typedef struct {
    bit          chk_data;
    logic [31:0] data;
    int          lat;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          fails  = 0;
  int          lat_cnt = 0;
  logic [31:0] shadow [0:255];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (m_valid && !m_ready) lat_cnt <= lat_cnt + 1;
    else                     lat_cnt <= 0;
  end

  // Monitor: pops the expected item when a handshake completes.
  always @(negedge clk) begin
    if (m_valid && m_ready) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R8 unexpected ready", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(lat_cnt == e.lat, {e.tag, " latency"}, lat_cnt, e.lat);
        if (e.chk_data) chk(m_rdata === e.data, {e.tag, " data"}, m_rdata, e.data);
      end
    end
  end

  task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                        input bit cd, input logic [31:0] ed, input int lat, input string tag);
    exp_t e;
    e.chk_data = cd; e.data = ed; e.lat = lat; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    m_valid = 1'b1; m_write = wr; m_addr = addr; m_wdata = wd;
    @(negedge clk);
    chk(m_hit == 1'b1, "R2 hit in window", m_hit, 1);
    while (!m_ready) @(negedge clk);
    @(posedge clk);
    #1 m_valid = 1'b0;
  endtask

  task automatic dwrite(input int idx, input logic [31:0] val);
    shadow[idx] = val;
    access(1'b1, BACK + idx * 4, val, 1'b0, '0, 1, "R3 direct write");
  endtask

  task automatic dread(input int idx, input string tag);
    access(1'b0, BACK + idx * 4, 32'hDEAD_BEEF, 1'b1, shadow[idx], 1, tag);
  endtask

  task automatic awrite(input int byte_off, input int bitn, input logic [31:0] val, input string tag);
    int idx, pos;
    idx = byte_off / 4;
    pos = (byte_off % 4) * 8 + bitn;
    shadow[idx][pos] = val[0];
    access(1'b1, ALIAS + byte_off * 32 + bitn * 4, val, 1'b0, '0, 2, tag);
  endtask

  task automatic aread(input int byte_off, input int bitn, input string tag);
    int idx, pos;
    idx = byte_off / 4;
    pos = (byte_off % 4) * 8 + bitn;
    access(1'b0, ALIAS + byte_off * 32 + bitn * 4, 32'hFFFF_FFFF, 1'b1,
           {31'b0, shadow[idx][pos]}, 1, tag);
  endtask

  task automatic miss(input logic [31:0] addr);
    @(negedge clk);
    m_valid = 1'b1; m_write = 1'b0; m_addr = addr;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(m_hit == 1'b0, "R2 miss hit low", m_hit, 0);
      chk(m_ready == 1'b0, "R2 miss not acked", m_ready, 0);
    end
    m_valid = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(m_ready == 1'b0, "R1 ready low in reset", m_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(m_ready == 1'b0, "R1 ready low after reset", m_ready, 0);
    chk(m_hit == 1'b0, "R1 no hit while idle", m_hit, 0);

    // R3: full-word pass-through
    dwrite(0, 32'h1234_5678);
    dwrite(1, 32'hFFFF_0000);
    dwrite(2, 32'h0000_0000);
    dwrite(3, 32'hA5A5_5A5A);
    dwrite(4, 32'h0000_0000);
    dwrite(5, 32'hA5A5_5A5A);
    dwrite(6, 32'hFFFF_FFFF);
    dread(0, "R3 read back");
    dread(1, "R3 read back");
    dread(3, "R3 read back");

    // R4: byte 0x10 bit 7 -> word 4 bit 7; R5: 0x01 sets
    awrite(16, 7, 32'h0000_0001, "R4 alias write");
    dread(4, "R4 mapped bit");
    // R5: 0xFF sets, 0x0E clears, 0xFE clears
    awrite(17, 3, 32'h0000_00FF, "R5 alias write 0xFF");
    dread(4, "R5 0xFF sets");
    awrite(16, 7, 32'h0000_000E, "R5 alias write 0x0E");
    dread(4, "R5 0x0E clears");
    awrite(17, 3, 32'hFFFF_FFFE, "R5 alias write 0xFFFFFFFE");
    dread(4, "R5 upper bits ignored");

    // R6: byte 0x17 -> word 5 lane 3, bit 2 -> position 26
    awrite(23, 2, 32'h1, "R6 alias set");
    dread(5, "R6 neighbours kept");
    awrite(20, 1, 32'h0, "R6 alias clear");
    dread(5, "R6 neighbours kept");
    awrite(27, 7, 32'h0, "R6 top bit clear");
    dread(6, "R6 neighbours kept");

    // R7: alias reads
    aread(23, 2, "R7 alias read set");
    aread(20, 1, "R7 alias read clear");
    aread(0, 3, "R7 alias read set");
    aread(27, 7, "R7 alias read clear");
    aread(24, 0, "R7 alias read set");

    // R9: back-to-back alias writes into one word
    awrite(8, 0, 32'h1, "R9 rmw first");
    awrite(8, 5, 32'h1, "R9 rmw second");
    awrite(11, 6, 32'h1, "R9 rmw third");
    dread(2, "R9 no lost update");

    // R2: out-of-window addresses
    miss(32'h1FFF_FFFC);
    miss(32'h2010_0000);
    miss(32'h21FF_FFFC);
    miss(32'h2400_0000);
    dread(0, "R2 memory untouched by misses");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R8 all accesses completed", sb.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule